// File: doc/BRIEF.md
# Compare-Match Timer Channel Array

This block holds several independent timer channels behind a small word-addressed register bus. Each channel owns an up-counter, a compare register and a control/status register. A channel counts only while its run bit, kept in one start/stop register shared by all channels, is set. It advances on ticks from its own prescaler, which divides the bus clock by 1, 8, 32 or 128.

When a tick finds the counter equal to the compare value, the counter returns to zero and a match flag is raised. When a tick takes the counter past all ones without a match, the counter wraps to zero and an overflow flag is raised. Software clears either flag by writing a 0 to its bit. Each channel has an interrupt line that follows its flags when the request-type field selects interrupts.

Every register write reaches its register through a fixed two-cycle write path. A count write is visible as pending in the status register until it lands.

Top module: `cmt_array`

## Requirements
- R1: After reset the start/stop register reads 0, every count reads 0, every compare reads all ones, every control/status register reads 0x0004, and all interrupt lines are low.
- R2: The start/stop register is at word 0, and run bit i belongs to channel i. Channel i uses words 4+4i (control/status), 5+4i (count) and 6+4i (compare). Read data appears one cycle after the read strobe. Words 1 to 3, the fourth word of each channel block, and any word past the last channel read as 0.
- R3: A write updates its register at the second clock edge after the edge that samples it. A read sampled one or two edges after the write returns the old value, and a read sampled three edges after returns the new value.
- R4: Control/status bits 2:0 pick the prescaler. Codes 4, 5, 6 and 7 give one count tick per 8, 32, 128 and 1 running cycles. The prescaler restarts from zero whenever the channel is stopped. Codes 0 to 3 never tick.
- R5: A tick with the count equal to the compare value loads 0 into the count and sets the match flag (bit 15). In continuous mode, k running ticks from zero leave the count at k mod (compare+1).
- R6: A tick at all ones with no match loads 0 and sets the overflow flag (bit 14). When the compare value is all ones, the match takes priority and the overflow flag stays clear.
- R7: Writing control/status with bit 15 or bit 14 at 0 clears that flag, and writing it at 1 leaves the flag unchanged. A flag event in the same cycle as a clear wins.
- R8: With bit 8 set the channel keeps running after a match. With bit 8 clear a match also clears that channel's run bit, and the count stays at 0.
- R9: A stopped channel holds its count. Writing 0 to the count of a stopped channel and reading it back returns 0.
- R10: Bit 13 of control/status is set from the edge that samples a count write until the edge that loads the value. A count write sampled while bit 13 is set is discarded.
- R11: A channel's interrupt is high exactly when its match or overflow flag is set and bits 5:4 equal 2. Values 0, 1 and 3 keep it low. It stays high until both flags are clear.
- R12: Channels are independent: writes to one channel and its run bit leave the other channels' registers and counts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data, valid the cycle after rd_en |
| irq | output | NCH | Per-channel interrupt lines |

## Verification
The hardest state to reach from the ports is a count write arriving while an earlier one is still in flight. Software is told to avoid it, and the window lasts only two cycles. The stimulus issues a count write, reads the status word on the very next edge to catch bit 13 high, and then writes the count again on the edge after that, inside the window. A later read then shows that the first value survived. The overflow path is reached by preloading the count just below all ones with a compare value far below it. Exact tick counts are produced by issuing start and stop writes a known number of edges apart, since both pass through the same two-cycle write path.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int CSR_W   = 16;
    localparam int CSR_CMF = 15;
    localparam int CSR_OVF = 14;
    localparam int CSR_WIP = 13;
    localparam int CSR_CMS = 8;
    localparam int CSR_IE  = 7;
    localparam int PRE_W   = 7;

    localparam logic [2:0] CKS_DIV8   = 3'd4;
    localparam logic [2:0] CKS_DIV32  = 3'd5;
    localparam logic [2:0] CKS_DIV128 = 3'd6;
    localparam logic [2:0] CKS_DIV1   = 3'd7;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        SEL_CSR  = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CMP  = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    typedef struct packed {
        logic       cms;
        logic       ie;
        req_e       req;
        logic [2:0] cks;
    } chan_cfg_t;

    // terminal prescaler count for a clock-select code
    function automatic logic [PRE_W-1:0] cks_limit(input logic [2:0] c);
        case (c)
            CKS_DIV8:   cks_limit = PRE_W'(7);
            CKS_DIV32:  cks_limit = PRE_W'(31);
            CKS_DIV128: cks_limit = PRE_W'(127);
            default:    cks_limit = '0;
        endcase
    endfunction

    // only the upper half of the code space produces ticks
    function automatic logic cks_counts(input logic [2:0] c);
        cks_counts = c[2];
    endfunction

endpackage

// File: rtl/cmt_delay.sv
module cmt_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic [W-1:0] stage_d [DEPTH+1];
    logic         stage_v [DEPTH+1];

    assign stage_d[0] = in_data;
    assign stage_v[0] = in_valid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_v[g+1] <= 1'b0;
                stage_d[g+1] <= '0;
            end else begin
                stage_v[g+1] <= stage_v[g];
                stage_d[g+1] <= stage_d[g];
            end
        end
    end

    assign out_valid = stage_v[DEPTH];
    assign out_data  = stage_d[DEPTH];
endmodule

// File: rtl/cmt_prescale.sv
module cmt_prescale
    import cmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;
    logic             en;

    always_comb begin
        lim  = cks_limit(cks);
        en   = run && cks_counts(cks);
        tick = en && (pre == lim);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) pre <= '0;
        else if (tick)  pre <= '0;
        else            pre <= pre + 1'b1;
    end

    // R4: a stopped prescaler starts its next run from zero
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre == '0));
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             wip_set,
    input  logic             wr_en,
    input  sel_e             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CSR_W-1:0] csr_rd,
    output logic [CNT_W-1:0] cnt_rd,
    output logic [CNT_W-1:0] cmp_rd,
    output logic             irq,
    output logic             stop_req
);
    chan_cfg_t        cfg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp;
    logic             cmf, ovf, wip;
    logic             tick, hit, wrapov;
    logic             wr_csr, wr_cnt, wr_cmp;

    cmt_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .cks  (cfg.cks),
        .tick (tick)
    );

    always_comb begin
        wr_csr   = wr_en && (wr_sel == SEL_CSR);
        wr_cnt   = wr_en && (wr_sel == SEL_CNT);
        wr_cmp   = wr_en && (wr_sel == SEL_CMP);
        hit      = tick && (cnt == cmp);
        wrapov   = tick && !hit && (cnt == '1);
        stop_req = hit && !cfg.cms;
        irq      = (cmf || ovf) && (cfg.req == REQ_IRQ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '{cms: 1'b0, ie: 1'b0, req: REQ_NONE, cks: CKS_DIV8};
            cnt <= '0;
            cmp <= '1;
            cmf <= 1'b0;
            ovf <= 1'b0;
            wip <= 1'b0;
        end else begin
            if (wr_csr) begin
                cfg.cms <= wr_data[CSR_CMS];
                cfg.ie  <= wr_data[CSR_IE];
                cfg.req <= req_e'(wr_data[5:4]);
                cfg.cks <= wr_data[2:0];
            end
            if (wr_cnt)     cnt <= wr_data;
            else if (hit)   cnt <= '0;
            else if (tick)  cnt <= cnt + 1'b1;
            if (wr_cmp)     cmp <= wr_data;
            if (hit)                             cmf <= 1'b1;
            else if (wr_csr && !wr_data[CSR_CMF]) cmf <= 1'b0;
            if (wrapov)                          ovf <= 1'b1;
            else if (wr_csr && !wr_data[CSR_OVF]) ovf <= 1'b0;
            if (wr_cnt)       wip <= 1'b0;
            else if (wip_set) wip <= 1'b1;
        end
    end

    always_comb begin
        csr_rd          = '0;
        csr_rd[CSR_CMF] = cmf;
        csr_rd[CSR_OVF] = ovf;
        csr_rd[CSR_WIP] = wip;
        csr_rd[CSR_CMS] = cfg.cms;
        csr_rd[CSR_IE]  = cfg.ie;
        csr_rd[5:4]     = cfg.req;
        csr_rd[2:0]     = cfg.cks;
        cnt_rd          = cnt;
        cmp_rd          = cmp;
    end

    // R5: a match restarts the count and raises the match flag
    a_r5_match_restart: assert property (@(posedge clk) disable iff (rst)
        (hit && !wr_cnt) |=> (cnt == '0) && cmf);
    // R6: wrap past all ones raises the overflow flag
    a_r6_overflow: assert property (@(posedge clk) disable iff (rst)
        (wrapov && !wr_cnt) |=> (cnt == '0) && ovf);
    // R7: a set match flag survives anything but a zero written to its bit
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (cmf && !(wr_csr && !wr_data[CSR_CMF])) |=> cmf);
    // R9: a stopped channel holds its count
    a_r9_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_cnt) |=> $stable(cnt));
    // R10: the pending flag is clear once the count value has landed
    a_r10_wip_done: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> !wip);
endmodule

// File: rtl/cmt_array.sv
module cmt_array
    import cmt_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int CNT_W    = 32,
    parameter int ADDR_W   = 8,
    parameter int WR_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [NCH-1:0]    irq
);
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PIPE_W = 1 + CH_W + 2 + CNT_W;
    localparam logic [ADDR_W-1:0] NCH_A = ADDR_W'(NCH);

    logic [NCH-1:0]    run;
    logic [NCH-1:0]    stop_req;
    logic [NCH-1:0]    wip_vec;
    logic [NCH-1:0]    wip_set;
    logic [CSR_W-1:0]  csr_rd [NCH];
    logic [CNT_W-1:0]  cnt_rd [NCH];
    logic [CNT_W-1:0]  cmp_rd [NCH];

    // bus decode
    logic              glob, blk, accept;
    logic [ADDR_W-1:0] chi_full;
    logic [CH_W-1:0]   chi;
    sel_e              sel;

    always_comb begin
        glob     = (addr == '0);
        chi_full = (addr >> 2) - ADDR_W'(1);
        blk      = (addr >= ADDR_W'(4)) && (chi_full < NCH_A);
        chi      = chi_full[CH_W-1:0];
        sel      = sel_e'(addr[1:0]);
        accept   = wr_en && (glob || (blk && (sel != SEL_NONE) &&
                   !((sel == SEL_CNT) && wip_vec[chi])));
    end

    // fixed-latency write path
    logic              ap_valid;
    logic [PIPE_W-1:0] ap_bus;
    logic              ap_glob;
    logic [CH_W-1:0]   ap_ch;
    sel_e              ap_sel;
    logic [CNT_W-1:0]  ap_data;

    cmt_delay #(.W(PIPE_W), .DEPTH(WR_DELAY)) u_wpipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_data   ({glob, chi, addr[1:0], wdata}),
        .out_valid (ap_valid),
        .out_data  (ap_bus)
    );

    always_comb begin
        ap_glob = ap_bus[PIPE_W-1];
        ap_ch   = ap_bus[CNT_W+2 +: CH_W];
        ap_sel  = sel_e'(ap_bus[CNT_W +: 2]);
        ap_data = ap_bus[CNT_W-1:0];
    end

    // shared start/stop register; a one-shot match wins over a write
    always_ff @(posedge clk) begin
        if (rst) run <= '0;
        else     run <= ((ap_valid && ap_glob) ? ap_data[NCH-1:0] : run) & ~stop_req;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wip_set[i] = accept && blk && (sel == SEL_CNT) && (chi == CH_W'(i));
        assign wip_vec[i] = csr_rd[i][CSR_WIP];

        cmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .run      (run[i]),
            .wip_set  (wip_set[i]),
            .wr_en    (ap_valid && !ap_glob && (ap_ch == CH_W'(i))),
            .wr_sel   (ap_sel),
            .wr_data  (ap_data),
            .csr_rd   (csr_rd[i]),
            .cnt_rd   (cnt_rd[i]),
            .cmp_rd   (cmp_rd[i]),
            .irq      (irq[i]),
            .stop_req (stop_req[i])
        );

        // R8: a one-shot match leaves the channel stopped
        a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
            stop_req[i] |=> !run[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (glob)     rdata <= CNT_W'(run);
            else if (blk) begin
                case (sel)
                    SEL_CSR: rdata <= CNT_W'(csr_rd[chi]);
                    SEL_CNT: rdata <= cnt_rd[chi];
                    SEL_CMP: rdata <= cmp_rd[chi];
                    default: rdata <= '0;
                endcase
            end else      rdata <= '0;
        end
    end

    // R10: a count write sampled while one is pending never enters the write path
    a_r10_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && blk && (sel == SEL_CNT) && wip_vec[chi]) |-> !accept);
endmodule

// File: tb/cmt_array_bench.sv
module cmt_array_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  irq;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        rd_d = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cmt_array u_cmt_array (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // all driver tasks start and end just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [1:0] e, input string tag);
        check(tag, 32'(irq), 32'(e));
    endtask

    // monitor: scoreboard pops one expectation per returned read
    always @(posedge clk) rd_d <= rst ? 1'b0 : rd_en;

    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL scoreboard: actual %h expected none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1 reset state
        chk_irq(2'b00, "R1 irq");
        rd(8'd0, 32'h0, "R1 run reg");
        rd(8'd4, 32'h0004, "R1 csr0");
        rd(8'd5, 32'h0, "R1 cnt0");
        rd(8'd6, 32'hFFFF_FFFF, "R1 cmp0");
        rd(8'd10, 32'hFFFF_FFFF, "R1 cmp1");
        rd(8'd3, 32'h0, "R2 unmapped word");
        rd(8'd7, 32'h0, "R2 unmapped channel word");
        rd(8'd12, 32'h0, "R2 past last channel");
        // R3 write latency
        wr(8'd6, 32'h1234);
        rd(8'd6, 32'hFFFF_FFFF, "R3 old one edge");
        rd(8'd6, 32'hFFFF_FFFF, "R3 old two edges");
        rd(8'd6, 32'h1234, "R3 new three edges");
        rd(8'd10, 32'hFFFF_FFFF, "R12 cmp1 untouched");
        // R5 continuous match, div 1, 12 ticks, compare 4
        wr(8'd4, 32'h0127);
        wr(8'd6, 32'd4);
        idle(3);
        wr(8'd0, 32'd1);
        idle(11);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd5, 32'd2, "R5 count mod period");
        rd(8'd4, 32'h8127, "R5 match flag");
        chk_irq(2'b01, "R11 irq on match");
        rd(8'd9, 32'd0, "R12 cnt1 untouched");
        // R7 flag clear semantics
        wr(8'd4, 32'hC127);
        idle(3);
        rd(8'd4, 32'h8127, "R7 ones keep flag");
        wr(8'd4, 32'h0127);
        idle(3);
        rd(8'd4, 32'h0127, "R7 zero clears flag");
        chk_irq(2'b00, "R11 irq drops");
        // R9 zero while stopped
        wr(8'd5, 32'd0);
        idle(3);
        rd(8'd5, 32'd0, "R9 zero readback");
        // R4 divide by 8, 20 running cycles
        wr(8'd4, 32'h0104);
        wr(8'd6, 32'd100);
        idle(3);
        wr(8'd0, 32'd1);
        idle(19);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd5, 32'd2, "R4 div8");
        // R4 divide by 32, 70 running cycles
        wr(8'd5, 32'd0);
        wr(8'd4, 32'h0105);
        idle(3);
        wr(8'd0, 32'd1);
        idle(69);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd5, 32'd2, "R4 div32");
        // R4 reserved code never ticks
        wr(8'd5, 32'd0);
        wr(8'd4, 32'h0100);
        idle(3);
        wr(8'd0, 32'd1);
        idle(9);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd5, 32'd0, "R4 reserved code");
        // R6 overflow on channel 1
        wr(8'd8, 32'h0127);
        wr(8'd10, 32'h10);
        wr(8'd9, 32'hFFFF_FFFE);
        idle(3);
        wr(8'd0, 32'd2);
        idle(2);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd9, 32'd1, "R6 wrapped count");
        rd(8'd8, 32'h4127, "R6 overflow flag");
        chk_irq(2'b10, "R11 irq on overflow");
        rd(8'd5, 32'd0, "R12 cnt0 untouched");
        // R6 match beats overflow at all ones
        wr(8'd8, 32'h0127);
        wr(8'd10, 32'hFFFF_FFFF);
        wr(8'd9, 32'hFFFF_FFFE);
        idle(3);
        rd(8'd8, 32'h0127, "R7 both flags cleared");
        chk_irq(2'b00, "R11 irq low after clear");
        wr(8'd0, 32'd2);
        idle(1);
        wr(8'd0, 32'd0);
        idle(3);
        rd(8'd9, 32'd0, "R6 priority count");
        rd(8'd8, 32'h8127, "R6 priority flags");
        // R11 request type gating
        wr(8'd8, 32'h8117);
        idle(3);
        chk_irq(2'b00, "R11 dma type gates irq");
        rd(8'd8, 32'h8117, "R11 flag kept");
        wr(8'd8, 32'h8127);
        idle(3);
        chk_irq(2'b10, "R11 irq type");
        wr(8'd8, 32'h0127);
        idle(3);
        chk_irq(2'b00, "R11 cleared");
        // R10 pending count write
        wr(8'd9, 32'h55);
        rd(8'd8, 32'h2127, "R10 pending bit");
        wr(8'd9, 32'h99);
        idle(3);
        rd(8'd9, 32'h55, "R10 second write dropped");
        rd(8'd8, 32'h0127, "R10 pending cleared");
        // R8 one-shot on channel 0
        wr(8'd5, 32'd0);
        wr(8'd4, 32'h0027);
        wr(8'd6, 32'd4);
        idle(3);
        wr(8'd0, 32'd1);
        idle(20);
        rd(8'd0, 32'd0, "R8 run bit cleared");
        rd(8'd5, 32'd0, "R8 count held at zero");
        rd(8'd4, 32'h8027, "R8 match flag");
        chk_irq(2'b01, "R11 one-shot irq");
        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule